// File: doc/BRIEF.md
# Triangle-Carrier Complementary PWM Generator

This block produces a pair of complementary pulse-width outputs for one power stage from a triangle carrier. A primary counter climbs from the dead-time value to the period value and falls back again. A secondary count trails it by the dead-time amount. The normal-phase output is active while the secondary count is above the active duty value. The counter-phase output is active while the primary count is below that value. Because of this, the two outputs are always separated by a gap of dead-time plus one counts and are never active together.

Software writes the duty value into a buffer register. The buffer is copied into the active compare register at one point of the carrier, chosen by a two-bit combination-mode field: at the valley (the secondary count reaching zero) or at the peak (the primary count reaching the period). A one-cycle pulse marks each copy. A separate one-cycle ADC trigger pulse can be enabled and placed at the peak or the valley. Each output has its own polarity bit. The combination-mode field is locked while either start bit is set.

The carrier sequencer has three states. CAR_IDLE holds the counters. It moves to CAR_UP once complementary mode is selected and both start bits are set. CAR_UP moves to CAR_DOWN at the peak. CAR_DOWN moves to CAR_UP at the valley. Every state returns to CAR_IDLE when the run condition drops.

Top module: `tri_cpwm_top`

## Requirements
- R1: After reset the control register (address 0) reads 0x80: bit 7 (external clock enable) is 1 and every other bit is 0. Both outputs are high, the ADC trigger and transfer pulses are 0, and the active duty register (address 5) reads 0.
- R2: The combination-mode field (control bits 1:0) keeps its value when the control register is written while either start bit (run register at address 1, bits 0 and 1) is 1. The other control bits are still written.
- R3: The carrier runs only when the mode field is 10b or 11b and both start bits are 1. Otherwise no ADC trigger or transfer pulse appears and both outputs stay at their idle levels.
- R4: With period P (address 2) and dead time D (address 3), the carrier repeats every 2*(P-D) clock cycles.
- R5: With active duty value C, where D < C and C+D < P, each carrier period has 2*(P-D-C)-1 cycles of normal-phase activity and 2*(C-D)-1 cycles of counter-phase activity, with no cycle in which both are active.
- R6: Control bit 2 sets the normal-phase polarity and control bit 3 sets the counter-phase polarity. A value of 0 means idle high and active low; a value of 1 means idle low and active high. Each bit affects only its own output.
- R7: Control bit 4 enables the ADC trigger. With this bit at 0, no trigger pulse is produced while the carrier runs.
- R8: Control bit 5 chooses the trigger point: 0 selects the peak, where the normal phase is active, and 1 selects the valley, where the counter phase is active. Each trigger is one cycle wide.
- R9: With mode 10b the buffer (address 4) is copied to the active duty register at the valley. With mode 11b the copy happens at the peak. The new value is readable in the same cycle as the transfer pulse.
- R10: Control bit 6 (three-phase select) has no effect on the outputs while complementary mode is selected.
- R11: The transfer pulse is one cycle wide and occurs only at the selected copy point.
- R12: When the start bits are cleared, both outputs return to the idle levels given by their polarity bits within three cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | CNT_W | Register read data (combinational) |
| pwm_norm | output | 1 | Normal-phase output |
| pwm_cntr | output | 1 | Counter-phase output |
| adc_trig | output | 1 | One-cycle ADC trigger pulse |
| buf_xfer | output | 1 | One-cycle buffer-transfer pulse |

## Verification
The hardest case to reach from the ports is a copy at the peak while the ADC trigger sits at the valley. Neither pulse then marks the moment of the copy. The bench aligns to a valley trigger and writes a new buffer value. It then counts exactly P-D cycles forward and reads the active duty register one cycle before and at the computed peak. The same alignment shows that the trigger lands where each output phase is active and that a locked mode field survives writes made while the carrier runs.

// File: rtl/tri_cpwm_pkg.sv
package tri_cpwm_pkg;

    localparam logic [2:0] ADDR_CTRL     = 3'd0;
    localparam logic [2:0] ADDR_RUN      = 3'd1;
    localparam logic [2:0] ADDR_PERIOD   = 3'd2;
    localparam logic [2:0] ADDR_DEAD     = 3'd3;
    localparam logic [2:0] ADDR_DUTY_BUF = 3'd4;
    localparam logic [2:0] ADDR_DUTY_ACT = 3'd5;

    localparam logic [7:0] CTRL_RESET = 8'h80;

    typedef enum logic [1:0] {
        CAR_IDLE = 2'd0,
        CAR_UP   = 2'd1,
        CAR_DOWN = 2'd2
    } car_state_t;

    typedef struct packed {
        logic       ext_clk_en;
        logic       three_phase;
        logic       adc_at_valley;
        logic       adc_en;
        logic       pol_cntr;
        logic       pol_norm;
        logic [1:0] combo;
    } ctrl_t;

endpackage

// File: rtl/tri_cpwm_regs.sv
module tri_cpwm_regs
    import tri_cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    input  logic             duty_load,
    output logic [1:0]       combo,
    output logic             pol_norm,
    output logic             pol_cntr,
    output logic             adc_en,
    output logic             adc_at_valley,
    output logic             start_a,
    output logic             start_b,
    output logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] dead,
    output logic [CNT_W-1:0] duty_buf,
    output logic [CNT_W-1:0] duty_act
);

    ctrl_t            ctrl_q;
    ctrl_t            ctrl_wr;
    logic [1:0]       run_q;
    logic             busy;
    logic [CNT_W-1:0] ctrl_rd;
    logic [CNT_W-1:0] run_rd;

    assign busy = run_q[0] | run_q[1];

    always_comb begin
        ctrl_wr = ctrl_t'(wr_data[7:0]);
        if (busy) begin
            ctrl_wr.combo = ctrl_q.combo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= ctrl_t'(CTRL_RESET);
            run_q    <= 2'b00;
            period   <= '0;
            dead     <= '0;
            duty_buf <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL:     ctrl_q   <= ctrl_wr;
                ADDR_RUN:      run_q    <= wr_data[1:0];
                ADDR_PERIOD:   period   <= wr_data;
                ADDR_DEAD:     dead     <= wr_data;
                ADDR_DUTY_BUF: duty_buf <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty_act <= '0;
        end else if (duty_load) begin
            duty_act <= duty_buf;
        end
    end

    always_comb begin
        ctrl_rd      = '0;
        ctrl_rd[7:0] = ctrl_q;
        run_rd       = '0;
        run_rd[1:0]  = run_q;
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_CTRL:     rd_data = ctrl_rd;
            ADDR_RUN:      rd_data = run_rd;
            ADDR_PERIOD:   rd_data = period;
            ADDR_DEAD:     rd_data = dead;
            ADDR_DUTY_BUF: rd_data = duty_buf;
            ADDR_DUTY_ACT: rd_data = duty_act;
            default:       rd_data = '0;
        endcase
    end

    assign combo         = ctrl_q.combo;
    assign pol_norm      = ctrl_q.pol_norm;
    assign pol_cntr      = ctrl_q.pol_cntr;
    assign adc_en        = ctrl_q.adc_en;
    assign adc_at_valley = ctrl_q.adc_at_valley;
    assign start_a       = run_q[0];
    assign start_b       = run_q[1];

endmodule

// File: rtl/tri_cpwm_carrier.sv
module tri_cpwm_carrier
    import tri_cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] dead,
    output car_state_t       state_q,
    output logic [CNT_W-1:0] cnt_a_q,
    output logic [CNT_W-1:0] cnt_b_q,
    output logic             peak_evt,
    output logic             valley_evt
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    car_state_t       state_d;
    logic [CNT_W-1:0] cnt_a_d;
    logic [CNT_W-1:0] cnt_b_d;

    assign peak_evt   = (state_q == CAR_UP)   && (cnt_a_q >= period);
    assign valley_evt = (state_q == CAR_DOWN) && (cnt_a_q <= dead);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (!go) begin
            state_d = CAR_IDLE;
        end else begin
            unique case (state_q)
                CAR_IDLE: state_d = CAR_UP;
                CAR_UP:   if (peak_evt)   state_d = CAR_DOWN;
                CAR_DOWN: if (valley_evt) state_d = CAR_UP;
                default:  state_d = CAR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter outputs of the sequencer
    always_comb begin
        cnt_a_d = cnt_a_q;
        if (!go) begin
            cnt_a_d = dead;
        end else begin
            unique case (state_q)
                CAR_IDLE: cnt_a_d = dead;
                CAR_UP: begin
                    if (!peak_evt) begin
                        cnt_a_d = cnt_a_q + STEP;
                    end else if (cnt_a_q > dead) begin
                        cnt_a_d = cnt_a_q - STEP;
                    end
                end
                CAR_DOWN: begin
                    if (valley_evt) begin
                        cnt_a_d = cnt_a_q + STEP;
                    end else begin
                        cnt_a_d = cnt_a_q - STEP;
                    end
                end
                default: cnt_a_d = dead;
            endcase
        end
        cnt_b_d = cnt_a_d - dead;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_a_q <= '0;
            cnt_b_q <= '0;
        end else begin
            cnt_a_q <= cnt_a_d;
            cnt_b_q <= cnt_b_d;
        end
    end

endmodule

// File: rtl/tri_cpwm_events.sv
module tri_cpwm_events (
    input  logic clk,
    input  logic rst_n,
    input  logic copy_at_peak,
    input  logic adc_en,
    input  logic adc_at_valley,
    input  logic peak_evt,
    input  logic valley_evt,
    output logic duty_load,
    output logic xfer_q,
    output logic adc_q
);

    logic adc_d;

    assign duty_load = copy_at_peak ? peak_evt : valley_evt;
    assign adc_d     = adc_en & (adc_at_valley ? valley_evt : peak_evt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xfer_q <= 1'b0;
            adc_q  <= 1'b0;
        end else begin
            xfer_q <= duty_load;
            adc_q  <= adc_d;
        end
    end

endmodule

// File: rtl/tri_cpwm_outstage.sv
module tri_cpwm_outstage #(
    parameter int CNT_W  = 8,
    parameter int PHASES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running,
    input  logic [CNT_W-1:0]  cnt_a,
    input  logic [CNT_W-1:0]  cnt_b,
    input  logic [CNT_W-1:0]  duty,
    input  logic [PHASES-1:0] pol,
    output logic [PHASES-1:0] act_q,
    output logic [PHASES-1:0] pin_q
);

    logic [PHASES-1:0] act_d;

    for (genvar i = 0; i < PHASES; i++) begin : g_phase
        if (i == 0) begin : g_norm
            assign act_d[i] = running && (cnt_b > duty);
        end else begin : g_cntr
            assign act_d[i] = running && (cnt_a < duty);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                act_q[i] <= 1'b0;
                pin_q[i] <= 1'b1;
            end else begin
                act_q[i] <= act_d[i];
                pin_q[i] <= ~(act_d[i] ^ pol[i]);
            end
        end
    end

endmodule

// File: rtl/tri_cpwm_top.sv
module tri_cpwm_top
    import tri_cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic             pwm_norm,
    output logic             pwm_cntr,
    output logic             adc_trig,
    output logic             buf_xfer
);

    localparam int PHASES = 2;

    logic [1:0]        combo;
    logic              pol_norm;
    logic              pol_cntr;
    logic              adc_en;
    logic              adc_at_valley;
    logic              start_a;
    logic              start_b;
    logic [CNT_W-1:0]  period;
    logic [CNT_W-1:0]  dead;
    logic [CNT_W-1:0]  duty_buf;
    logic [CNT_W-1:0]  duty_act;
    logic              duty_load;
    logic              run_go;
    car_state_t        car_state;
    logic [CNT_W-1:0]  cnt_a;
    logic [CNT_W-1:0]  cnt_b;
    logic              peak_evt;
    logic              valley_evt;
    logic              running;
    logic [PHASES-1:0] act_q;
    logic [PHASES-1:0] pin_q;

    assign run_go  = combo[1] & start_a & start_b;
    assign running = (car_state != CAR_IDLE);

    tri_cpwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .duty_load(duty_load),
        .combo(combo), .pol_norm(pol_norm), .pol_cntr(pol_cntr),
        .adc_en(adc_en), .adc_at_valley(adc_at_valley),
        .start_a(start_a), .start_b(start_b),
        .period(period), .dead(dead),
        .duty_buf(duty_buf), .duty_act(duty_act)
    );

    tri_cpwm_carrier #(.CNT_W(CNT_W)) carrier_i (
        .clk(clk), .rst_n(rst_n), .go(run_go),
        .period(period), .dead(dead),
        .state_q(car_state), .cnt_a_q(cnt_a), .cnt_b_q(cnt_b),
        .peak_evt(peak_evt), .valley_evt(valley_evt)
    );

    tri_cpwm_events events_i (
        .clk(clk), .rst_n(rst_n),
        .copy_at_peak(combo[0]), .adc_en(adc_en), .adc_at_valley(adc_at_valley),
        .peak_evt(peak_evt), .valley_evt(valley_evt),
        .duty_load(duty_load), .xfer_q(buf_xfer), .adc_q(adc_trig)
    );

    tri_cpwm_outstage #(.CNT_W(CNT_W), .PHASES(PHASES)) out_i (
        .clk(clk), .rst_n(rst_n), .running(running),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .duty(duty_act),
        .pol({pol_cntr, pol_norm}),
        .act_q(act_q), .pin_q(pin_q)
    );

    assign pwm_norm = pin_q[0];
    assign pwm_cntr = pin_q[1];

endmodule

// File: rtl/tri_cpwm_chk.sv
module tri_cpwm_chk
    import tri_cpwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_a,
    input logic             start_b,
    input logic [1:0]       combo,
    input logic             run_go,
    input car_state_t       car_state,
    input logic             adc_trig,
    input logic             buf_xfer,
    input logic [1:0]       act_q,
    input logic [CNT_W-1:0] duty_buf,
    input logic [CNT_W-1:0] duty_act
);

    // R2
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_a || start_b) |=> $stable(combo));

    // R3
    idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_go |=> (car_state == CAR_IDLE));

    // R5
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_q[0] && act_q[1]));

    // R8
    trig_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |=> !adc_trig);

    // R11
    xfer_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_xfer |=> !buf_xfer);

    // R9
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_xfer) |-> (duty_act == $past(duty_buf)));

endmodule

bind tri_cpwm_top tri_cpwm_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .start_a(start_a), .start_b(start_b),
    .combo(combo), .run_go(run_go), .car_state(car_state),
    .adc_trig(adc_trig), .buf_xfer(buf_xfer), .act_q(act_q),
    .duty_buf(duty_buf), .duty_act(duty_act)
);

// File: tb/tri_cpwm_top_tb_top.sv
module tri_cpwm_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int P          = 40;
    localparam int D          = 4;
    localparam int WD_LIMIT   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [CNT_W-1:0] rd_data;
    logic             pwm_norm, pwm_cntr, adc_trig, buf_xfer;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    tri_cpwm_top #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_norm(pwm_norm), .pwm_cntr(pwm_cntr),
        .adc_trig(adc_trig), .buf_xfer(buf_xfer)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_LIMIT);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        rd_addr = a;
        #1;
        d = int'(rd_data);
    endtask

    task automatic wait_trig(input string req);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!adc_trig && k < 1000);
        if (!adc_trig) chk(1'b0, req, k, 2*(P-D));
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    // counts active cycles over one carrier period starting at the current sample
    task automatic window(input bit pn, input bit pc, output int wn, output int wc, output int both);
        wn = 0; wc = 0; both = 0;
        for (int i = 0; i < 2*(P-D); i++) begin
            if (pwm_norm == pn) wn++;
            if (pwm_cntr == pc) wc++;
            if (pwm_norm == pn && pwm_cntr == pc) both++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int v;
        rd(3'd0, v);
        chk(v == 8'h80, "R1 ctrl reset", v, 8'h80);
        rd(3'd5, v);
        chk(v == 0, "R1 duty_act reset", v, 0);
        chk(pwm_norm && pwm_cntr, "R1 outputs high", {pwm_norm, pwm_cntr}, 3);
        chk(!adc_trig && !buf_xfer, "R1 pulses low", {adc_trig, buf_xfer}, 0);
    endtask

    task automatic t_inactive;
        int trig = 0;
        int idle_bad = 0;
        wr(3'd2, P); wr(3'd3, D); wr(3'd4, 16);
        // mode 00 with both start bits
        wr(3'd0, 8'h10); wr(3'd1, 3);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (adc_trig || buf_xfer) trig++;
            if (!pwm_norm || !pwm_cntr) idle_bad++;
        end
        chk(trig == 0 && idle_bad == 0, "R3 mode 00 idle", trig + idle_bad, 0);
        // mode 01
        wr(3'd1, 0); wr(3'd0, 8'h11); wr(3'd1, 3);
        trig = 0; idle_bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (adc_trig || buf_xfer) trig++;
            if (!pwm_norm || !pwm_cntr) idle_bad++;
        end
        chk(trig == 0 && idle_bad == 0, "R3 mode 01 idle", trig + idle_bad, 0);
        // mode 10 with one start bit
        wr(3'd1, 0); wr(3'd0, 8'h12); wr(3'd1, 1);
        trig = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (adc_trig || buf_xfer) trig++;
        end
        chk(trig == 0, "R3 single start bit", trig, 0);
    endtask

    task automatic t_mode_guard;
        int v;
        // start_a only set from previous scenario: mode write is locked
        wr(3'd0, 8'h13);
        rd(3'd0, v);
        chk((v & 3) == 2, "R2 locked with one start bit", v & 3, 2);
        wr(3'd1, 3);
        wr(3'd0, 8'h14);
        rd(3'd0, v);
        chk(v == 8'h16, "R2 locked running, others written", v, 8'h16);
        wr(3'd0, 8'h12);
        rd(3'd0, v);
        chk(v == 8'h12, "R2 restore", v, 8'h12);
    endtask

    task automatic t_carrier;
        int t0, t1, wn, wc, both;
        repeat (3) wait_trig("R4 trigger missing");
        t0 = cyc;
        @(negedge clk);
        chk(!adc_trig, "R8 trigger one cycle", adc_trig, 0);
        wait_trig("R4 trigger missing");
        t1 = cyc;
        chk(t1 - t0 == 2*(P-D), "R4 carrier period", t1 - t0, 2*(P-D));
        chk(pwm_norm == 1'b0 && pwm_cntr == 1'b1, "R8 peak trigger, normal active",
            {pwm_norm, pwm_cntr}, 1);
        window(1'b0, 1'b0, wn, wc, both);
        chk(wn == 2*(P-D-16)-1, "R5 normal width", wn, 2*(P-D-16)-1);
        chk(wc == 2*(16-D)-1, "R5 counter width", wc, 2*(16-D)-1);
        chk(both == 0, "R5 overlap", both, 0);
    endtask

    task automatic t_xfer_valley;
        int prev, cur;
        wr(3'd0, 8'h32);
        wait_trig("R8 valley trigger missing");
        chk(pwm_norm == 1'b1 && pwm_cntr == 1'b0, "R8 valley trigger, counter active",
            {pwm_norm, pwm_cntr}, 2);
        wr(3'd4, 20);
        rd_addr = 3'd5;
        #1;
        cur = int'(rd_data);
        do begin
            prev = cur;
            @(negedge clk);
            cur = int'(rd_data);
        end while (!adc_trig && cyc < WD_LIMIT);
        chk(prev == 16, "R9 mode 10 old before valley", prev, 16);
        chk(cur == 20, "R9 mode 10 new at valley", cur, 20);
        chk(buf_xfer == 1'b1, "R11 xfer with valley", buf_xfer, 1);
        @(negedge clk);
        chk(buf_xfer == 1'b0, "R11 xfer one cycle", buf_xfer, 0);
    endtask

    task automatic t_xfer_peak;
        int n0, v;
        wr(3'd1, 0);
        wr(3'd0, 8'h33);
        wr(3'd1, 3);
        repeat (3) wait_trig("R9 valley trigger missing");
        n0 = cyc;
        wr(3'd4, 24);
        rd_addr = 3'd5;
        wait_until(n0 + (P-D) - 1);
        #1 v = int'(rd_data);
        chk(v == 20 && !buf_xfer, "R9 mode 11 old before peak", v, 20);
        wait_until(n0 + (P-D));
        #1 v = int'(rd_data);
        chk(v == 24, "R9 mode 11 new at peak", v, 24);
        chk(buf_xfer == 1'b1, "R11 xfer at peak", buf_xfer, 1);
    endtask

    task automatic t_polarity_running;
        int wn, wc, both;
        wr(3'd0, 8'h37);
        repeat (2) wait_trig("R6 trigger missing");
        window(1'b1, 1'b0, wn, wc, both);
        chk(wn == 2*(P-D-24)-1, "R6 active-high normal width", wn, 2*(P-D-24)-1);
        chk(wc == 2*(24-D)-1, "R6 active-low counter width", wc, 2*(24-D)-1);
        chk(both == 0, "R5 overlap mixed polarity", both, 0);
        wr(3'd0, 8'h77);
        repeat (2) wait_trig("R10 trigger missing");
        window(1'b1, 1'b0, wn, wc, both);
        chk(wn == 2*(P-D-24)-1 && wc == 2*(24-D)-1, "R10 three-phase bit no effect",
            wn * 100 + wc, (2*(P-D-24)-1) * 100 + 2*(24-D)-1);
    endtask

    task automatic t_adc_off;
        int trig = 0;
        int xf = 0;
        wr(3'd0, 8'h23);
        @(negedge clk);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (adc_trig) trig++;
            if (buf_xfer) xf++;
        end
        chk(trig == 0, "R7 trigger disabled", trig, 0);
        chk(xf >= 2, "R7 carrier still running", xf, 2);
    endtask

    task automatic t_stop;
        int bad = 0;
        wr(3'd0, 8'h2F);
        wr(3'd1, 0);
        repeat (3) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (pwm_norm || pwm_cntr || adc_trig) bad++;
            @(negedge clk);
        end
        chk(bad == 0, "R12 idle low after stop", bad, 0);
        wr(3'd0, 8'h0A);
        repeat (2) @(negedge clk);
        chk(pwm_norm == 1'b1 && pwm_cntr == 1'b0, "R6 independent idle levels",
            {pwm_norm, pwm_cntr}, 2);
        wr(3'd0, 8'h06);
        repeat (2) @(negedge clk);
        chk(pwm_norm == 1'b0 && pwm_cntr == 1'b1, "R6 independent idle levels swapped",
            {pwm_norm, pwm_cntr}, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_inactive();
        t_mode_guard();
        t_carrier();
        t_xfer_valley();
        t_xfer_peak();
        t_polarity_running();
        t_adc_off();
        t_stop();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule